// File: doc/BRIEF.md
# Fuse Array Command Sequencer

This block lets software read and burn single words of a one-time-programmable fuse array through a small register window. Software loads a word address and, for a burn, the data word. It then writes a full 32-bit ASCII command word. A read is started by "READ" (0x44414552). A burn is started by "BLOW" (0x574F4C42). Any other command value does nothing at the fuse port.

A burn has one more condition. The key register must hold the ASCII key "OPEN" (0x4E45504F), written since the last command that consumed it. Software therefore writes the key again before each burned word.

While an operation runs, the sequencer holds one strobe towards the fuse macro until the macro answers with ready. At that point it raises a per-direction completion flag, which software clears by writing one to it. After a read, the fetched word is in the data register. Rejected burns and out-of-range addresses leave the fuse port quiet and set a sticky error bit.

The macro itself is assumed to OR a burned word into the stored one, since fuse bits can only go from 0 to 1. The sequencer passes the data word through unchanged.

Top module: `fuse_seq_top`

## Requirements
- R1: After reset, every readable register reads 0 and both fuse strobes are low.
- R2: Writing 0x44414552 to offset 3 while idle, with the address register (offset 1, bits 15:0) below NWORDS, raises `fz_read` at that address. When `fz_ready` is seen, the data register (offset 2) takes `fz_rdata` and flag bit 0 (read-done, offset 4) sets.
- R3: Writing 0x574F4C42 to offset 3 while idle and unlocked, with an in-range address, raises `fz_prog`. It carries the address and the data register on `fz_wdata`. When `fz_ready` is seen, flag bit 1 (write-done) sets.
- R4: A burn command given while locked produces no strobe and leaves write-done clear. It also sets sticky flag bit 2 (error).
- R5: Writing 0x4E45504F to offset 0 unlocks the block, and offset 0 bit 0 reads 1 while unlocked. Writing any other key value locks it. A burn command, or any command value other than the read code, locks it again. A read command leaves it unchanged.
- R6: A command value that is neither code produces no strobe and leaves all flags unchanged.
- R7: Writing 1 to a bit of offset 4 clears that flag, and writing 0 leaves it. When a flag sets in the same cycle, the set wins.
- R8: While an operation runs, flag bit 3 (busy) reads 1, and writes to offsets 1, 2 and 3 are ignored.
- R9: A read or burn command with an address at or above NWORDS produces no strobe and no done flag, and sets the error bit. A burn command rejected this way still locks the block.
- R10: Exactly one strobe is high at a time. It stays high, with a stable address, until the cycle in which `fz_ready` is high, and drops after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_ofs | input | OFS_W | Register word offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_ofs` (combinational) |
| fz_addr | output | FA_W | Fuse word address |
| fz_wdata | output | 32 | Word to burn |
| fz_read | output | 1 | Read strobe, held until ready |
| fz_prog | output | 1 | Burn strobe, held until ready |
| fz_ready | input | 1 | Macro completion |
| fz_rdata | input | 32 | Word read from the macro |

## Verification
The bench builds the block with NWORDS = 24, a count that is not a power of two. With it, the address comparison can see an in-range word at 23 and a rejected one at 24, both inside the 5-bit macro address. The behavioural macro answers reads after 6 cycles and burns after 3. The longer read window leaves room to write registers and commands while the block is busy. The shorter burn window exercises a different wait length through the same strobe logic.

// File: rtl/fuse_seq_pkg.sv
// Package: shared codes, register offsets and sequencer states for the fuse
// command sequencer. Assumes a 32-bit register bus.
package fuse_seq_pkg;
    localparam int          BUS_W    = 32;
    localparam logic [31:0] KEY_OPEN = 32'h4E45504F;
    localparam logic [31:0] CODE_RD  = 32'h44414552;
    localparam logic [31:0] CODE_PG  = 32'h574F4C42;

    localparam int OFS_KEY  = 0;
    localparam int OFS_ADDR = 1;
    localparam int OFS_DATA = 2;
    localparam int OFS_CMD  = 3;
    localparam int OFS_FLAG = 4;

    localparam int FB_RD   = 0;
    localparam int FB_WR   = 1;
    localparam int FB_ERR  = 2;
    localparam int FB_BUSY = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_PROG = 2'd2
    } seq_state_e;
endpackage

// File: rtl/fuse_seq_cmd.sv
// Command decoder and unlock tracker. Decides whether a command write
// starts a read, starts a burn or is rejected, and keeps the one-shot
// unlock state. Assumes cmd_wr is only meaningful while the sequencer is idle.
module fuse_seq_cmd
    import fuse_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic             cmd_wr,
    input  logic [BUS_W-1:0] wval,
    input  logic             idle,
    input  logic             addr_ok,
    output logic             start_rd,
    output logic             start_pg,
    output logic             reject,
    output logic             unlocked
);
    logic cmd_go;
    logic is_rd;
    logic is_pg;

    // Classify the written command word.
    always_comb begin
        cmd_go   = cmd_wr && idle;
        is_rd    = (wval == CODE_RD);
        is_pg    = (wval == CODE_PG);
        start_rd = cmd_go && is_rd && addr_ok;
        start_pg = cmd_go && is_pg && unlocked && addr_ok;
        reject   = cmd_go && ((is_pg && !unlocked) || ((is_rd || is_pg) && !addr_ok));
    end

    // Track the unlock key; consumed by every accepted command except a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
        end else if (key_wr) begin
            unlocked <= (wval == KEY_OPEN);
        end else if (cmd_go && !is_rd) begin
            unlocked <= 1'b0;
        end
    end
endmodule

// File: rtl/fuse_seq_port.sv
// Fuse-macro port sequencer. Latches address and data at start, holds a
// single strobe until the macro reports ready, then returns to idle.
// Assumes start_rd and start_pg never arrive together and only while idle.
module fuse_seq_port
    import fuse_seq_pkg::*;
#(
    parameter int FA_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_rd,
    input  logic             start_pg,
    input  logic [FA_W-1:0]  addr_in,
    input  logic [BUS_W-1:0] data_in,
    input  logic             fz_ready,
    output logic [FA_W-1:0]  fz_addr,
    output logic [BUS_W-1:0] fz_wdata,
    output logic             fz_read,
    output logic             fz_prog,
    output logic             idle,
    output logic             rd_done,
    output logic             wr_done
);
    seq_state_e state;

    // Advance the operation state and latch the operands at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            fz_addr  <= '0;
            fz_wdata <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_rd || start_pg) begin
                        fz_addr  <= addr_in;
                        fz_wdata <= data_in;
                        state    <= start_rd ? ST_READ : ST_PROG;
                    end
                end
                ST_READ, ST_PROG: begin
                    if (fz_ready) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode strobes and completion pulses from the state.
    always_comb begin
        fz_read = (state == ST_READ);
        fz_prog = (state == ST_PROG);
        idle    = (state == ST_IDLE);
        rd_done = fz_read && fz_ready;
        wr_done = fz_prog && fz_ready;
    end
endmodule

// File: rtl/fuse_seq_regs.sv
// Register file: address and data registers, write-one-to-clear flags and
// the read-back multiplexer. Assumes the data register is reloaded from the
// macro on read completion, which only happens while busy.
module fuse_seq_regs
    import fuse_seq_pkg::*;
#(
    parameter int OFS_W      = 3,
    parameter int ADDR_REG_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [OFS_W-1:0]      reg_ofs,
    input  logic [BUS_W-1:0]      reg_wdata,
    input  logic                  idle,
    input  logic                  unlocked,
    input  logic                  rd_done,
    input  logic                  wr_done,
    input  logic                  reject,
    input  logic [BUS_W-1:0]      rd_word,
    output logic [ADDR_REG_W-1:0] addr_q,
    output logic [BUS_W-1:0]      data_q,
    output logic                  flag_rd,
    output logic                  flag_wr,
    output logic                  flag_err,
    output logic [BUS_W-1:0]      reg_rdata
);
    logic wr_addr;
    logic wr_data;
    logic wr_flag;

    // Decode writes; operand registers are writable only while idle.
    always_comb begin
        wr_addr = reg_wr && idle && (reg_ofs == OFS_W'(OFS_ADDR));
        wr_data = reg_wr && idle && (reg_ofs == OFS_W'(OFS_DATA));
        wr_flag = reg_wr && (reg_ofs == OFS_W'(OFS_FLAG));
    end

    // Hold the word address and the data word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (wr_addr) addr_q <= reg_wdata[ADDR_REG_W-1:0];
            if (rd_done) data_q <= rd_word;
            else if (wr_data) data_q <= reg_wdata;
        end
    end

    // Done and error flags: hardware set wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_rd  <= 1'b0;
            flag_wr  <= 1'b0;
            flag_err <= 1'b0;
        end else begin
            if (rd_done) flag_rd <= 1'b1;
            else if (wr_flag && reg_wdata[FB_RD]) flag_rd <= 1'b0;
            if (wr_done) flag_wr <= 1'b1;
            else if (wr_flag && reg_wdata[FB_WR]) flag_wr <= 1'b0;
            if (reject) flag_err <= 1'b1;
            else if (wr_flag && reg_wdata[FB_ERR]) flag_err <= 1'b0;
        end
    end

    // Read-back multiplexer; the command offset reads as zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_ofs)
            OFS_W'(OFS_KEY):  reg_rdata[0] = unlocked;
            OFS_W'(OFS_ADDR): reg_rdata[ADDR_REG_W-1:0] = addr_q;
            OFS_W'(OFS_DATA): reg_rdata = data_q;
            OFS_W'(OFS_FLAG): begin
                reg_rdata[FB_RD]   = flag_rd;
                reg_rdata[FB_WR]   = flag_wr;
                reg_rdata[FB_ERR]  = flag_err;
                reg_rdata[FB_BUSY] = !idle;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fuse_seq_top.sv
// Top of the fuse command sequencer: register window, command decoder and
// fuse-macro port. Assumes one register write per cycle and a macro that
// raises ready for exactly one cycle per strobe.
module fuse_seq_top
    import fuse_seq_pkg::*;
#(
    parameter int NWORDS     = 64,
    parameter int OFS_W      = 3,
    parameter int ADDR_REG_W = 16,
    localparam int FA_W      = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [OFS_W-1:0]  reg_ofs,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [FA_W-1:0]   fz_addr,
    output logic [31:0]       fz_wdata,
    output logic              fz_read,
    output logic              fz_prog,
    input  logic              fz_ready,
    input  logic [31:0]       fz_rdata
);
    localparam logic [ADDR_REG_W-1:0] ADDR_LIM = ADDR_REG_W'(NWORDS);

    logic [ADDR_REG_W-1:0] addr_q;
    logic [BUS_W-1:0]      data_q;
    logic seq_idle, unlocked, addr_ok;
    logic start_rd, start_pg, reject;
    logic rd_done, wr_done;
    logic flag_rd, flag_wr, flag_err;
    logic key_wr, cmd_wr;

    // Route bus writes to the key and command decoders; check the address.
    always_comb begin
        key_wr  = reg_wr && (reg_ofs == OFS_W'(OFS_KEY));
        cmd_wr  = reg_wr && (reg_ofs == OFS_W'(OFS_CMD));
        addr_ok = (addr_q < ADDR_LIM);
    end

    fuse_seq_cmd u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .cmd_wr   (cmd_wr),
        .wval     (reg_wdata),
        .idle     (seq_idle),
        .addr_ok  (addr_ok),
        .start_rd (start_rd),
        .start_pg (start_pg),
        .reject   (reject),
        .unlocked (unlocked)
    );

    fuse_seq_port #(.FA_W(FA_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_rd (start_rd),
        .start_pg (start_pg),
        .addr_in  (addr_q[FA_W-1:0]),
        .data_in  (data_q),
        .fz_ready (fz_ready),
        .fz_addr  (fz_addr),
        .fz_wdata (fz_wdata),
        .fz_read  (fz_read),
        .fz_prog  (fz_prog),
        .idle     (seq_idle),
        .rd_done  (rd_done),
        .wr_done  (wr_done)
    );

    fuse_seq_regs #(.OFS_W(OFS_W), .ADDR_REG_W(ADDR_REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_ofs   (reg_ofs),
        .reg_wdata (reg_wdata),
        .idle      (seq_idle),
        .unlocked  (unlocked),
        .rd_done   (rd_done),
        .wr_done   (wr_done),
        .reject    (reject),
        .rd_word   (fz_rdata),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .flag_rd   (flag_rd),
        .flag_wr   (flag_wr),
        .flag_err  (flag_err),
        .reg_rdata (reg_rdata)
    );
endmodule

// File: rtl/fuse_seq_chk.sv
// Checker for the fuse command sequencer: strobe protocol, completion
// timing, unlock rules and address range. Attached to the top by bind.
module fuse_seq_chk #(
    parameter int NWORDS = 64,
    parameter int FA_W   = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fz_read,
    input logic            fz_prog,
    input logic            fz_ready,
    input logic [FA_W-1:0] fz_addr,
    input logic            unlocked,
    input logic            flag_rd,
    input logic            flag_wr,
    input logic            seq_idle
);
    localparam logic [FA_W:0] LIM = (FA_W + 1)'(NWORDS);

    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fz_read && fz_prog));
    p_hold_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((fz_read || fz_prog) && !fz_ready) |=> ($stable(fz_read) && $stable(fz_prog) && $stable(fz_addr)));
    p_drop_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((fz_read || fz_prog) && fz_ready) |=> !(fz_read || fz_prog));
    p_rdone_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_rd) |-> $past(fz_read && fz_ready));
    p_wdone_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_wr) |-> $past(fz_prog && fz_ready));
    p_prog_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fz_prog) |-> $past(unlocked));
    p_key_used_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fz_prog) |-> !unlocked);
    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fz_read || fz_prog) |-> !seq_idle);
    p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fz_read || fz_prog) |-> ({1'b0, fz_addr} < LIM));
endmodule

bind fuse_seq_top fuse_seq_chk #(.NWORDS(NWORDS), .FA_W(FA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fz_read  (fz_read),
    .fz_prog  (fz_prog),
    .fz_ready (fz_ready),
    .fz_addr  (fz_addr),
    .unlocked (unlocked),
    .flag_rd  (flag_rd),
    .flag_wr  (flag_wr),
    .seq_idle (seq_idle)
);

// File: tb/tb_fuse_seq_top.sv
`timescale 1ns/1ps
module tb_fuse_seq_top;
    localparam int NW     = 24;
    localparam int FAW    = 5;
    localparam int RD_LAT = 6;
    localparam int PG_LAT = 3;
    localparam logic [31:0] K_OPEN = 32'h4E45504F;
    localparam logic [31:0] C_RD   = 32'h44414552;
    localparam logic [31:0] C_PG   = 32'h574F4C42;

    // vector: {op(1: burn, 0: read), addr[7:0], data[31:0], expect[31:0]}
    localparam int NV = 10;
    localparam logic [72:0] VEC [NV] = '{
        {1'b0, 8'd5,  32'h0,        32'hA5A50000},
        {1'b0, 8'd0,  32'h0,        32'h00000000},
        {1'b1, 8'd3,  32'h000000F0, 32'h00000002},
        {1'b0, 8'd3,  32'h0,        32'h000000F0},
        {1'b1, 8'd3,  32'h00000F0F, 32'h00000002},
        {1'b0, 8'd3,  32'h0,        32'h00000FFF},
        {1'b1, 8'd23, 32'h80000001, 32'h00000002},
        {1'b0, 8'd23, 32'h0,        32'h80000001},
        {1'b1, 8'd5,  32'h00005A5A, 32'h00000002},
        {1'b0, 8'd5,  32'h0,        32'hA5A55A5A}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_ofs = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [FAW-1:0] fz_addr;
    logic [31:0] fz_wdata;
    logic fz_read, fz_prog;
    logic fz_ready;
    logic [31:0] fz_rdata;

    int nchk = 0;
    int nbad = 0;
    int rd_starts = 0;
    int pg_starts = 0;
    logic rd_q, pg_q;
    logic [31:0] mem [NW];
    int lat_cnt;

    always #2.5 clk = ~clk;

    fuse_seq_top #(.NWORDS(NW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ofs(reg_ofs),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fz_addr(fz_addr),
        .fz_wdata(fz_wdata), .fz_read(fz_read), .fz_prog(fz_prog),
        .fz_ready(fz_ready), .fz_rdata(fz_rdata)
    );

    // Behavioural fuse macro: fixed latencies, burns OR into the stored word.
    always @(posedge clk) begin
        if (!rst_n) begin
            fz_ready <= 1'b0;
            fz_rdata <= '0;
            lat_cnt  <= 0;
            for (int i = 0; i < NW; i++) mem[i] <= (i == 5) ? 32'hA5A50000 : 32'h0;
        end else if (fz_ready) begin
            fz_ready <= 1'b0;
            lat_cnt  <= 0;
        end else if (fz_read || fz_prog) begin
            if (lat_cnt == (fz_read ? RD_LAT : PG_LAT) - 1) begin
                fz_ready <= 1'b1;
                if (fz_prog) mem[fz_addr] <= mem[fz_addr] | fz_wdata;
                else fz_rdata <= mem[fz_addr];
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // Count strobe starts.
    always @(posedge clk) begin
        rd_q <= fz_read;
        pg_q <= fz_prog;
        if (rst_n && fz_read && !rd_q) rd_starts <= rd_starts + 1;
        if (rst_n && fz_prog && !pg_q) pg_starts <= pg_starts + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int ofs, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_ofs = 3'(ofs); reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int ofs, output logic [31:0] val);
        @(negedge clk);
        reg_ofs = 3'(ofs);
        #1 val = reg_rdata;
    endtask

    task automatic poll(input int bitn, input string req);
        logic [31:0] f;
        bit seen = 0;
        for (int i = 0; i < 64 && !seen; i++) begin
            rd(4, f);
            seen = f[bitn];
        end
        if (!seen) check(req, 32'h0, 32'h1);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int s0, s1;
        wait_cyc(3);
        rst_n = 1'b1;
        // R1: reset state
        for (int o = 0; o < 5; o++) begin
            rd(o, v);
            check("R1 reg", v, 32'h0);
        end
        check("R1 strobes", {30'b0, fz_read, fz_prog}, 32'h0);

        // R2/R3 vector walk
        for (int k = 0; k < NV; k++) begin
            wr(4, 32'h7);
            wr(1, 32'(VEC[k][71:64]));
            if (VEC[k][72]) begin
                wr(0, K_OPEN);
                wr(2, VEC[k][63:32]);
                wr(3, C_PG);
                poll(1, "R3 done");
                rd(4, v);
                check("R3 flags", v, VEC[k][31:0]);
            end else begin
                wr(3, C_RD);
                poll(0, "R2 done");
                rd(2, v);
                check("R2 data", v, VEC[k][31:0]);
            end
        end

        // R4: burn while locked
        wr(4, 32'h7);
        wr(0, 32'h0);
        wr(1, 32'd2);
        wr(2, 32'hFFFFFFFF);
        s0 = pg_starts;
        wr(3, C_PG);
        wait_cyc(10);
        rd(4, v);
        check("R4 flags", v, 32'h4);
        check("R4 no strobe", 32'(pg_starts), 32'(s0));
        wr(3, C_RD);
        poll(0, "R4 read back");
        rd(2, v);
        check("R4 fuse untouched", v, 32'h0);

        // R5: unlock state
        wr(4, 32'h7);
        wr(0, K_OPEN);
        rd(0, v);
        check("R5 unlocked", v, 32'h1);
        wr(3, C_RD);
        poll(0, "R5 read");
        rd(0, v);
        check("R5 kept by read", v, 32'h1);
        wr(3, 32'h12345678);
        rd(0, v);
        check("R5 locked by other", v, 32'h0);
        wr(0, K_OPEN);
        wr(0, 32'h4E45504E);
        rd(0, v);
        check("R5 wrong key", v, 32'h0);

        // R6: unknown command
        wr(4, 32'h7);
        s0 = rd_starts; s1 = pg_starts;
        wr(3, 32'h44414553);
        wait_cyc(10);
        rd(4, v);
        check("R6 flags", v, 32'h0);
        check("R6 strobes", 32'(rd_starts + pg_starts), 32'(s0 + s1));

        // R7: write-one-to-clear
        wr(1, 32'd0);
        wr(3, C_RD);
        poll(0, "R7 set");
        wr(4, 32'h0);
        rd(4, v);
        check("R7 zero write", v, 32'h1);
        wr(4, 32'h1);
        rd(4, v);
        check("R7 one clears", v, 32'h0);

        // R8: writes while busy
        wr(1, 32'd5);
        s0 = rd_starts;
        wr(3, C_RD);
        rd(4, v);
        check("R8 busy", v & 32'h8, 32'h8);
        wr(1, 32'd7);
        wr(2, 32'h11111111);
        wr(3, C_RD);
        poll(0, "R8 done");
        rd(1, v);
        check("R8 addr kept", v, 32'd5);
        rd(2, v);
        check("R8 data from fuse", v, 32'hA5A55A5A);
        check("R8 one start", 32'(rd_starts), 32'(s0 + 1));

        // R9: address range
        wr(4, 32'h7);
        wr(1, 32'd24);
        s0 = rd_starts; s1 = pg_starts;
        wr(3, C_RD);
        wait_cyc(10);
        rd(4, v);
        check("R9 read flags", v, 32'h4);
        wr(4, 32'h7);
        wr(0, K_OPEN);
        wr(3, C_PG);
        wait_cyc(10);
        rd(4, v);
        check("R9 burn flags", v, 32'h4);
        rd(0, v);
        check("R9 key consumed", v, 32'h0);
        check("R9 no strobe", 32'(rd_starts + pg_starts), 32'(s0 + s1));

        // R10: strobe released after ready
        wr(1, 32'd23);
        wr(3, C_RD);
        poll(0, "R10 done");
        check("R10 strobes low", {30'b0, fz_read, fz_prog}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule